// File: doc/BRIEF.md
# Reduced Four-State Two-Input Moore Recognizer

This block is a Moore state machine. It takes a two-bit input symbol on each clock and drives a one-bit flag. Its behaviour is defined by a six-state transition table. The machine here is the minimized equivalent of that table: two pairs of equivalent states are merged, which leaves four states. Those four states fit in a two-bit register with no unused codes.

The flag is decoded from the state register alone and never from the input. A symbol applied before a rising edge therefore shows up on the flag just after that edge. Reset is synchronous and active-low, and it puts the machine in the merged start state, where the flag reads 1. In the descriptions below, the four states are named P (the merge of original states 0 and 4), S1, S2 and Q (the merge of original states 3 and 5).

Top module: `moore_reduced4`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, the machine enters state P and `flag_out` reads 1 after that edge, whatever `sel_in` is.
- R2: `flag_out` is 1 in states P and S2 and 0 in states S1 and Q. It depends on the state only: changing `sel_in` between edges leaves `flag_out` unchanged.
- R3: From P, the symbols 00, 01, 10 and 11 lead to P, S1, S2 and Q respectively.
- R4: From S1, the symbols 00, 01, 10 and 11 lead to P, Q, S1 and Q respectively.
- R5: From S2, the symbols 00, 01, 10 and 11 lead to S1, Q, S2 and P respectively.
- R6: From Q, the symbols 00, 01, 10 and 11 lead to S1, P, P and Q respectively.
- R7: For every input sequence applied after reset, `flag_out` matches the output of the six-state table, cycle by cycle. That table has states 0 to 5, with output 1 in states 0, 2 and 4. For symbols 00/01/10/11 its transitions are:
  - 0 → 0/1/2/3
  - 1 → 0/3/1/5
  - 2 → 1/3/2/4
  - 3 → 1/0/4/5
  - 4 → 0/1/2/5
  - 5 → 1/4/0/5

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_in | input | 2 | Input symbol, sampled at each rising edge |
| flag_out | output | 1 | Moore output decoded from the current state |

## Verification
A symbol driven before rising edge k decides the state after edge k, and `flag_out` reflects that state straight away, so each result is due one edge after its stimulus. The bench drives `sel_in` and `rst_n` on the falling edge and steps its own reduced and six-state models at the rising edge. It compares `flag_out` on the next falling edge, which keeps the check exactly one register stage behind the stimulus. The state-only dependence (R2) is checked inside a single half cycle: the input is changed several times with no edge in between, and the flag must hold the value of the current state.

// File: rtl/msm_pkg.sv
// Shared widths and the state encoding for the reduced Moore recognizer.
// Assumes the two-bit encoding fills every code, so no illegal state exists.
package msm_pkg;
    localparam int IN_W = 2;
    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_P  = 2'b00,
        ST_S1 = 2'b01,
        ST_S2 = 2'b10,
        ST_Q  = 2'b11
    } state_t;
endpackage

// File: rtl/msm_next.sv
// Next-state function of the reduced machine.
// Purely combinational; assumes the caller registers the result.
module msm_next
    import msm_pkg::*;
(
    input  state_t          cur,
    input  logic [IN_W-1:0] sel,
    output state_t          nxt
);
    // Pick the successor of the current state for the applied symbol.
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_P: begin
                unique case (sel)
                    2'b00:   nxt = ST_P;
                    2'b01:   nxt = ST_S1;
                    2'b10:   nxt = ST_S2;
                    default: nxt = ST_Q;
                endcase
            end
            ST_S1: begin
                unique case (sel)
                    2'b00:   nxt = ST_P;
                    2'b01:   nxt = ST_Q;
                    2'b10:   nxt = ST_S1;
                    default: nxt = ST_Q;
                endcase
            end
            ST_S2: begin
                unique case (sel)
                    2'b00:   nxt = ST_S1;
                    2'b01:   nxt = ST_Q;
                    2'b10:   nxt = ST_S2;
                    default: nxt = ST_P;
                endcase
            end
            default: begin
                unique case (sel)
                    2'b00:   nxt = ST_S1;
                    2'b01:   nxt = ST_P;
                    2'b10:   nxt = ST_P;
                    default: nxt = ST_Q;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/msm_state_reg.sv
// State register with a synchronous active-low reset to the start state.
// Assumes rst_n is synchronous to clk.
module msm_state_reg
    import msm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t d,
    output state_t q
);
    // Capture the next state, or return to the start state under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ST_P;
        else        q <= d;
    end
endmodule

// File: rtl/msm_out_dec.sv
// Moore output decoder: the flag is a function of the state only.
// Assumes no input reaches this logic.
module msm_out_dec
    import msm_pkg::*;
(
    input  state_t st,
    output logic   flag
);
    // Raise the flag in the two states whose output is 1.
    always_comb begin
        unique case (st)
            ST_P, ST_S2: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/moore_reduced4.sv
// Top of the reduced four-state two-input Moore recognizer.
// Assumes one symbol per clock and a synchronous active-low reset.
module moore_reduced4
    import msm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] sel_in,
    output logic            flag_out
);
    state_t state_q;
    state_t state_d;

    msm_next u_next (
        .cur (state_q),
        .sel (sel_in),
        .nxt (state_d)
    );

    msm_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    msm_out_dec u_dec (
        .st   (state_q),
        .flag (flag_out)
    );
endmodule

// File: rtl/moore_reduced4_chk.sv
// Property checker for the reduced recognizer, attached with bind.
// Assumes it observes the top ports and the registered state.
module moore_reduced4_chk
    import msm_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [IN_W-1:0] sel_in,
    input logic            flag_out,
    input state_t          state_q
);
    // R1
    reset_to_p_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_P) && flag_out);

    // R2
    s1_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S1) |-> !flag_out);

    // R3
    p_to_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_P && sel_in == 2'b11) |=> (state_q == ST_Q));

    // R4
    s1_to_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S1 && sel_in == 2'b01) |=> (state_q == ST_Q) && !flag_out);

    // R5
    s2_to_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S2 && sel_in == 2'b11) |=> (state_q == ST_P) && flag_out);

    // R6
    q_to_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Q && sel_in == 2'b10) |=> (state_q == ST_P));
endmodule

bind moore_reduced4 moore_reduced4_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (sel_in),
    .flag_out (flag_out),
    .state_q  (state_q)
);

// File: tb/moore_reduced4_tb.sv
module moore_reduced4_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       flag;
    int checks = 0;
    int errors = 0;
    int ref_s = 0;
    int red_s = 0;

    moore_reduced4 u_dut (.clk(clk), .rst_n(rst_n), .sel_in(sel), .flag_out(flag));

    always #5 clk = ~clk;

    // Six-state table from R7.
    function automatic int ref_next(int s, logic [1:0] v);
        case (s)
            0: case (v) 2'b00: return 0; 2'b01: return 1; 2'b10: return 2; default: return 3; endcase
            1: case (v) 2'b00: return 0; 2'b01: return 3; 2'b10: return 1; default: return 5; endcase
            2: case (v) 2'b00: return 1; 2'b01: return 3; 2'b10: return 2; default: return 4; endcase
            3: case (v) 2'b00: return 1; 2'b01: return 0; 2'b10: return 4; default: return 5; endcase
            4: case (v) 2'b00: return 0; 2'b01: return 1; 2'b10: return 2; default: return 5; endcase
            default: case (v) 2'b00: return 1; 2'b01: return 4; 2'b10: return 0; default: return 5; endcase
        endcase
    endfunction

    function automatic logic ref_out(int s);
        return (s == 0 || s == 2 || s == 4);
    endfunction

    // Reduced table from R3..R6: 0=P 1=S1 2=S2 3=Q.
    function automatic int red_next(int s, logic [1:0] v);
        case (s)
            0: case (v) 2'b00: return 0; 2'b01: return 1; 2'b10: return 2; default: return 3; endcase
            1: case (v) 2'b00: return 0; 2'b01: return 3; 2'b10: return 1; default: return 3; endcase
            2: case (v) 2'b00: return 1; 2'b01: return 3; 2'b10: return 2; default: return 0; endcase
            default: case (v) 2'b00: return 1; 2'b01: return 0; 2'b10: return 0; default: return 3; endcase
        endcase
    endfunction

    function automatic logic red_out(int s);
        return (s == 0 || s == 2);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, step the models at the rising edge, check at the next falling edge.
    task automatic tick(logic r, logic [1:0] v);
        string tag;
        sel = v;
        rst_n = r;
        if (!r) tag = "R1";
        else case (red_s)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
        endcase
        @(posedge clk);
        if (!r) begin
            ref_s = 0;
            red_s = 0;
        end else begin
            ref_s = ref_next(ref_s, v);
            red_s = red_next(red_s, v);
        end
        @(negedge clk);
        chk(tag, flag, red_out(red_s));
        chk("R7", flag, ref_out(ref_s));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] path [4];
        path[0] = 2'b00; path[1] = 2'b01; path[2] = 2'b10; path[3] = 2'b11;
        void'($urandom(32'h1234_abcd));
        @(negedge clk);
        tick(1'b0, 2'b11);                  // R1 from power-up

        // Directed sweep over every reduced state and symbol (R3..R6).
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 4; v++) begin
                tick(1'b0, 2'b00);
                if (s > 0) tick(1'b1, path[s]);
                tick(1'b1, v[1:0]);
            end
        end

        // R2: the flag holds while the input changes between edges.
        for (int s = 0; s < 4; s++) begin
            tick(1'b0, 2'b00);
            if (s > 0) tick(1'b1, path[s]);
            for (int v = 0; v < 4; v++) begin
                sel = v[1:0];
                #1;
                chk("R2", flag, (s == 0 || s == 2));
            end
        end

        // R1: reset from a state whose flag is low.
        tick(1'b0, 2'b00);
        tick(1'b1, 2'b11);
        tick(1'b0, 2'b01);
        tick(1'b1, 2'b01);

        // R7: random comparison with occasional resets.
        for (int i = 0; i < 4000; i++) begin
            tick(($urandom % 64) != 0, 2'($urandom % 4));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule